// File: doc/BRIEF.md
# Far-End Alarm Channel Codeword Controller

This block sends and receives 6-bit alarm and control codewords on a channel that carries one bit per frame. Framing and bit extraction happen elsewhere. A one-cycle strobe marks each frame's channel bit. The transmitter wraps each codeword in a 16-bit pattern and shifts out one bit per strobe. It has three modes. Single mode sends a short burst and then stops. Repeat mode sends one codeword with no end. Alternate mode interleaves two codewords in runs. A loopback command is a pair of codewords, an activate or deactivate code and a line-select code, so alternate mode is the one that carries it.

The receiver watches the incoming channel bits and locks onto the pattern. It accepts a codeword only after the codeword has shown up often enough in recent pattern slots. Each accepted codeword goes into a small first-in first-out queue. The host can then read several codewords in a row at its own pace.

Top module: `feac_ctrl`

## Requirements
- R1: After reset, and whenever no codeword is being sent, `tx_line` stays 1. After reset `rx_empty` is 1, `tx_done` is 0 and `rx_ovf` is 0.
- R2: Each codeword is sent as 16 bits, one bit per `frame_stb`, with `tx_line` changing only at a strobe. Bits 0 to 7 of the pattern are 1. Bit 8 is 0. Bits 9 to 14 carry the code, with code bit 0 first. Bit 15 is 0.
- R3: Mode code 1 is single mode. A `tx_start` pulse arms a burst and clears `tx_done`. At the next pattern boundary, `tx_code_a` is sent 10 times in a row, after which the line goes back to all ones. `tx_done` rises at the strobe that sends the last bit of the tenth pattern.
- R4: Mode code 2 is repeat mode. `tx_code_a` is sent back-to-back for as long as the mode is held.
- R5: Mode code 3 is alternate mode. `tx_code_a` is sent 10 times, then `tx_code_b` 10 times, and so on, always starting with `tx_code_a`, until the mode changes. Mode code 0 is idle.
- R6: Pattern boundaries fall on every 16th strobe, counted from reset. A change of `tx_mode` is sampled only at a boundary, so a pattern that has started always finishes.
- R7: The receiver accepts a codeword once 8 of the last 10 pattern slots carried that same codeword. Seven out of ten is not enough.
- R8: An accepted codeword is queued only once per run. A valid pattern carrying a different code starts a new run, and that new code can then be accepted.
- R9: The queue holds 4 codewords in arrival order. `rx_code` shows the oldest entry, `rx_pop` removes it, and `rx_empty` is 1 when the queue holds none.
- R10: A codeword accepted while the queue is full is dropped. It leaves the queue contents unchanged and raises `rx_ovf` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per frame channel bit |
| tx_mode | input | 2 | 0 idle, 1 single, 2 repeat, 3 alternate |
| tx_code_a | input | 6 | First or only transmit codeword |
| tx_code_b | input | 6 | Second codeword for alternate mode |
| tx_start | input | 1 | Arms a single-mode burst |
| tx_line | output | 1 | Transmit channel bit |
| tx_done | output | 1 | Single-mode burst complete |
| rx_line | input | 1 | Received channel bit, sampled at the strobe |
| rx_pop | input | 1 | Remove the oldest queued codeword |
| rx_code | output | 6 | Oldest queued codeword |
| rx_empty | output | 1 | Queue holds no codeword |
| rx_ovf | output | 1 | Pulse: an accepted codeword was dropped |

## Verification
A wrong bit position or repeat counter in the transmitter moves a zero to the wrong place on `tx_line`. The bench compares the line bit by bit against its own model, so that fault shows at the first strobe where it matters. It also moves the strobe at which `tx_done` rises. A wrong receive history or wrong run tracking shows up at the queue. A codeword can appear one slot early or late, appear twice in one run, or fail to appear. Queue pointer or occupancy faults show up as a wrong order, a missing `rx_ovf` pulse, or `rx_empty` not clearing once the expected entries have been read.

// File: rtl/feac_pkg.sv
package feac_pkg;
    localparam int CODE_W     = 6;
    localparam int ONES_LEN   = 8;
    localparam int PAT_LEN    = ONES_LEN + CODE_W + 2;
    localparam int CNT_W      = $clog2(PAT_LEN);
    localparam int IDX_W      = $clog2(CODE_W);
    localparam int TX_REPS    = 10;
    localparam int RX_WIN     = 10;
    localparam int RX_CONFIRM = 8;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_REPEAT = 2'd2,
        MODE_ALT    = 2'd3
    } tx_mode_e;

    typedef struct packed {
        logic  active;
        code_t code;
    } tx_pat_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } rx_word_t;

    // Bit at position idx of the framed pattern for codeword c.
    function automatic logic pat_bit(code_t c, int idx);
        logic [IDX_W-1:0] k;
        if (idx < ONES_LEN) return 1'b1;
        if (idx == ONES_LEN || idx == PAT_LEN - 1) return 1'b0;
        k = IDX_W'(idx - ONES_LEN - 1);
        return c[k];
    endfunction

    // Checks a 16-bit window (oldest bit at the MSB) and extracts the code.
    function automatic rx_word_t decode_window(logic [PAT_LEN-1:0] w);
        rx_word_t r;
        r.valid = (&w[PAT_LEN-1 -: ONES_LEN]) && !w[PAT_LEN-1-ONES_LEN] && !w[0];
        for (int i = 0; i < CODE_W; i++) begin
            r.code[i] = w[PAT_LEN-2-ONES_LEN-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/feac_tx.sv
module feac_tx
    import feac_pkg::*;
#(
    parameter int REPS = TX_REPS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     stb,
    input  tx_mode_e mode,
    input  code_t    code_a,
    input  code_t    code_b,
    input  logic     start,
    output logic     line,
    output logic     done
);
    localparam int REP_W = $clog2(REPS + 1);

    logic [CNT_W-1:0] pos;
    tx_pat_t          pat, nxt_pat, cur_pat;
    logic [REP_W-1:0] rep, nxt_rep, base_rep;
    logic             sel_b, nxt_sel, base_sel;
    logic             armed, nxt_armed;
    logic             last, nxt_last;
    tx_mode_e         cur_mode;
    logic             boundary;
    logic             line_d;

    assign boundary = (pos == '0);

    always_comb begin
        nxt_pat   = pat;
        nxt_rep   = rep;
        nxt_sel   = sel_b;
        nxt_armed = armed;
        nxt_last  = last;
        base_rep  = (cur_mode == MODE_ALT) ? rep : '0;
        base_sel  = (cur_mode == MODE_ALT) ? sel_b : 1'b0;
        if (boundary) begin
            nxt_last = 1'b0;
            nxt_pat  = '{active: 1'b0, code: code_a};
            unique case (mode)
                MODE_IDLE: ;
                MODE_SINGLE: begin
                    if (armed) begin
                        nxt_pat.active = 1'b1;
                        nxt_rep        = rep + REP_W'(1);
                        if (rep == REP_W'(REPS - 1)) begin
                            nxt_armed = 1'b0;
                            nxt_last  = 1'b1;
                        end
                    end
                end
                MODE_REPEAT: nxt_pat.active = 1'b1;
                MODE_ALT: begin
                    if (base_rep == REP_W'(REPS)) begin
                        nxt_sel = ~base_sel;
                        nxt_rep = REP_W'(1);
                    end else begin
                        nxt_sel = base_sel;
                        nxt_rep = base_rep + REP_W'(1);
                    end
                    nxt_pat.active = 1'b1;
                    nxt_pat.code   = nxt_sel ? code_b : code_a;
                end
            endcase
        end
        cur_pat = boundary ? nxt_pat : pat;
        line_d  = cur_pat.active ? pat_bit(cur_pat.code, int'(pos)) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            pat      <= '0;
            rep      <= '0;
            sel_b    <= 1'b0;
            armed    <= 1'b0;
            last     <= 1'b0;
            done     <= 1'b0;
            line     <= 1'b1;
            cur_mode <= MODE_IDLE;
        end else begin
            if (stb) begin
                pos   <= (pos == CNT_W'(PAT_LEN - 1)) ? '0 : pos + CNT_W'(1);
                pat   <= nxt_pat;
                rep   <= nxt_rep;
                sel_b <= nxt_sel;
                armed <= nxt_armed;
                line  <= line_d;
                if (boundary) begin
                    cur_mode <= mode;
                    last     <= nxt_last;
                end
                if (pos == CNT_W'(PAT_LEN - 1) && last) begin
                    done <= 1'b1;
                    last <= 1'b0;
                end
            end
            if (start) begin
                armed <= 1'b1;
                rep   <= '0;
                done  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/feac_rx.sv
module feac_rx
    import feac_pkg::*;
#(
    parameter int CONFIRM = RX_CONFIRM
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  logic  line,
    output logic  push,
    output code_t push_code
);
    localparam int HC_W = $clog2(RX_WIN + 1);

    logic [PAT_LEN-1:0] shreg, shreg_n;
    logic               locked;
    logic [CNT_W-1:0]   slot;
    code_t              cand;
    logic [RX_WIN-1:0]  hist, hist_n;
    logic               reported, rep_n;
    logic               eval, new_run;
    logic [HC_W-1:0]    hits;
    rx_word_t           win;

    always_comb begin
        shreg_n = {shreg[PAT_LEN-2:0], line};
        win     = decode_window(shreg_n);
        eval    = stb && locked && (slot == CNT_W'(PAT_LEN - 1));
        new_run = win.valid && (win.code != cand);
        if (win.valid && !new_run)
            hist_n = {hist[RX_WIN-2:0], 1'b1};
        else if (new_run)
            hist_n = RX_WIN'(1);
        else
            hist_n = {hist[RX_WIN-2:0], 1'b0};
        rep_n = new_run ? 1'b0 : reported;
        hits  = '0;
        for (int i = 0; i < RX_WIN; i++) begin
            hits = hits + HC_W'(hist_n[i]);
        end
        push      = eval && !rep_n && (hits >= HC_W'(CONFIRM));
        push_code = new_run ? win.code : cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '1;
            locked   <= 1'b0;
            slot     <= '0;
            cand     <= '0;
            hist     <= '0;
            reported <= 1'b0;
        end else if (stb) begin
            shreg <= shreg_n;
            if (!locked) begin
                if (win.valid) begin
                    locked   <= 1'b1;
                    cand     <= win.code;
                    hist     <= RX_WIN'(1);
                    slot     <= '0;
                    reported <= 1'b0;
                end
            end else begin
                slot <= (slot == CNT_W'(PAT_LEN - 1)) ? '0 : slot + CNT_W'(1);
                if (eval) begin
                    hist     <= hist_n;
                    cand     <= push_code;
                    reported <= rep_n | push;
                    if (hist_n == '0) locked <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/feac_fifo.sv
module feac_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, rd_ok, wr_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_ok   = pop && !empty;
    assign wr_ok   = push && (!full || rd_ok);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf <= push && !wr_ok;
            if (wr_ok) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            if (wr_ok && !rd_ok)      count <= count + CW'(1);
            else if (rd_ok && !wr_ok) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/feac_ctrl.sv
module feac_ctrl
    import feac_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int REPS       = TX_REPS,
    parameter int CONFIRM    = RX_CONFIRM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [1:0]        tx_mode,
    input  logic [CODE_W-1:0] tx_code_a,
    input  logic [CODE_W-1:0] tx_code_b,
    input  logic              tx_start,
    output logic              tx_line,
    output logic              tx_done,
    input  logic              rx_line,
    input  logic              rx_pop,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_empty,
    output logic              rx_ovf
);
    logic  q_push;
    code_t q_code;

    feac_tx #(.REPS(REPS)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .stb    (frame_stb),
        .mode   (tx_mode_e'(tx_mode)),
        .code_a (tx_code_a),
        .code_b (tx_code_b),
        .start  (tx_start),
        .line   (tx_line),
        .done   (tx_done)
    );

    feac_rx #(.CONFIRM(CONFIRM)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .stb       (frame_stb),
        .line      (rx_line),
        .push      (q_push),
        .push_code (q_code)
    );

    feac_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (q_push),
        .wr_data (q_code),
        .pop     (rx_pop),
        .rd_data (rx_code),
        .empty   (rx_empty),
        .ovf     (rx_ovf)
    );
endmodule

// File: rtl/feac_ctrl_chk.sv
module feac_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic frame_stb,
    input logic tx_start,
    input logic tx_line,
    input logic tx_done,
    input logic rx_empty,
    input logic rx_ovf
);
    p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(tx_line));

    p_done_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tx_start && !frame_stb) |=> $stable(tx_done));

    p_done_on_last_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> !tx_line);

    p_fill_on_stb_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_empty) |-> $past(frame_stb));

    p_ovf_on_stb_r10: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> $past(frame_stb));

    p_ovf_not_empty_r10: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> !rx_empty);
endmodule

bind feac_ctrl feac_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .tx_start  (tx_start),
    .tx_line   (tx_line),
    .tx_done   (tx_done),
    .rx_empty  (rx_empty),
    .rx_ovf    (rx_ovf)
);

// File: tb/feac_ctrl_bench.sv
module feac_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STB_GAP    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [1:0] tx_mode = 2'd0;
    logic [5:0] tx_code_a = '0;
    logic [5:0] tx_code_b = '0;
    logic       tx_start = 1'b0;
    logic       tx_line;
    logic       tx_done;
    logic       rx_line = 1'b1;
    logic       rx_pop = 1'b0;
    logic [5:0] rx_code;
    logic       rx_empty;
    logic       rx_ovf;

    int         nchk = 0;
    int         nerr = 0;
    int         ovf_cnt = 0;
    logic       stb_seen = 1'b0;
    logic       mon_en = 1'b1;
    logic       use_loop = 1'b1;
    logic       inj_bit = 1'b1;
    string      tx_tag = "R1";
    logic       exp_tx[$];
    logic [5:0] exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    feac_ctrl u_feac_ctrl (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .tx_mode(tx_mode),
        .tx_code_a(tx_code_a), .tx_code_b(tx_code_b), .tx_start(tx_start),
        .tx_line(tx_line), .tx_done(tx_done), .rx_line(rx_line), .rx_pop(rx_pop),
        .rx_code(rx_code), .rx_empty(rx_empty), .rx_ovf(rx_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [5:0] c, input int i);
        if (i < 8) return 1'b1;
        if (i == 8 || i == 15) return 1'b0;
        return c[i-9];
    endfunction

    // Monitor: scoreboard compare of transmit bits and queued receive codes.
    always @(posedge clk) stb_seen <= frame_stb;

    always @(negedge clk) begin
        if (!rst) begin
            if (stb_seen) begin
                if (exp_tx.size() == 0) chk(1'b0, "R2 extra tx bit", int'(tx_line), 0);
                else begin
                    logic e;
                    e = exp_tx.pop_front();
                    chk(tx_line == e, tx_tag, int'(tx_line), int'(e));
                end
            end
            if (rx_ovf) ovf_cnt++;
            rx_pop = 1'b0;
            if (mon_en && !rx_empty) begin
                if (exp_rx.size() == 0) chk(1'b0, "R8 unexpected rx code", int'(rx_code), 0);
                else begin
                    logic [5:0] ec;
                    ec = exp_rx.pop_front();
                    chk(rx_code == ec, "R9 rx code order", int'(rx_code), int'(ec));
                end
                rx_pop = 1'b1;
            end
        end
    end

    // Driver: one strobe, with its expected transmit bit queued first.
    task automatic step(input logic e);
        exp_tx.push_back(e);
        @(negedge clk);
        rx_line   = use_loop ? tx_line : inj_bit;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (STB_GAP - 2) @(negedge clk);
    endtask

    task automatic tx_pattern(input logic [5:0] c);
        for (int i = 0; i < 16; i++) step(exp_bit(c, i));
    endtask

    task automatic tx_ones(input int npat);
        for (int i = 0; i < npat * 16; i++) step(1'b1);
    endtask

    task automatic inj_pattern(input logic [5:0] c);
        for (int i = 0; i < 16; i++) begin
            inj_bit = exp_bit(c, i);
            step(1'b1);
        end
    endtask

    task automatic inj_ones(input int npat);
        inj_bit = 1'b1;
        for (int i = 0; i < npat * 16; i++) step(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(tx_line == 1'b1, "R1 reset tx_line", int'(tx_line), 1);
        chk(rx_empty == 1'b1, "R1 reset rx_empty", int'(rx_empty), 1);
        chk(tx_done == 1'b0, "R1 reset tx_done", int'(tx_done), 0);
        chk(rx_ovf == 1'b0, "R1 reset rx_ovf", int'(rx_ovf), 0);

        // R1 idle, then R6 mid-pattern mode change, R4 repeat
        tx_tag = "R1 idle line";
        tx_ones(1);
        for (int i = 0; i < 5; i++) step(1'b1);
        tx_mode   = 2'd2;
        tx_code_a = 6'h15;
        tx_tag    = "R6 change waits for boundary";
        for (int i = 0; i < 11; i++) step(1'b1);
        tx_tag = "R4 repeat";
        exp_rx.push_back(6'h15);
        for (int p = 0; p < 12; p++) tx_pattern(6'h15);
        tx_mode = 2'd0;
        tx_tag  = "R1 idle line";
        tx_ones(12);

        // R3 single burst
        tx_mode   = 2'd1;
        tx_code_a = 6'h2C;
        @(negedge clk) tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        chk(tx_done == 1'b0, "R3 done cleared by start", int'(tx_done), 0);
        exp_rx.push_back(6'h2C);
        tx_tag = "R3 single burst";
        for (int p = 0; p < 9; p++) tx_pattern(6'h2C);
        for (int i = 0; i < 15; i++) step(exp_bit(6'h2C, i));
        chk(tx_done == 1'b0, "R3 done before last bit", int'(tx_done), 0);
        step(1'b0);
        chk(tx_done == 1'b1, "R3 done at last bit", int'(tx_done), 1);
        tx_tag = "R3 idle after burst";
        tx_ones(12);
        tx_mode = 2'd0;

        // R5 alternate, R8 new run per code change
        tx_mode   = 2'd3;
        tx_code_a = 6'h01;
        tx_code_b = 6'h3E;
        tx_tag    = "R5 alternate";
        for (int r = 0; r < 4; r++) begin
            exp_rx.push_back((r % 2 == 1) ? 6'h3E : 6'h01);
            for (int k = 0; k < 10; k++) tx_pattern((r % 2 == 1) ? 6'h3E : 6'h01);
        end
        tx_mode = 2'd0;
        tx_tag  = "R1 idle line";
        tx_ones(12);

        // R10 overflow with the monitor held off, then R9 drain order
        mon_en    = 1'b0;
        tx_mode   = 2'd3;
        tx_code_a = 6'h0A;
        tx_code_b = 6'h13;
        tx_tag    = "R5 alternate";
        for (int r = 0; r < 6; r++)
            for (int k = 0; k < 10; k++) tx_pattern((r % 2 == 1) ? 6'h13 : 6'h0A);
        tx_mode = 2'd0;
        tx_tag  = "R1 idle line";
        tx_ones(12);
        chk(ovf_cnt == 2, "R10 overflow pulses", ovf_cnt, 2);
        chk(rx_empty == 1'b0, "R9 queue holds entries", int'(rx_empty), 0);
        exp_rx.push_back(6'h0A);
        exp_rx.push_back(6'h13);
        exp_rx.push_back(6'h0A);
        exp_rx.push_back(6'h13);
        mon_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(exp_rx.size() == 0, "R10 kept first four", exp_rx.size(), 0);
        chk(rx_empty == 1'b1, "R9 empty after drain", int'(rx_empty), 1);

        // R7 seven of ten is not enough, eight of ten is
        use_loop = 1'b0;
        tx_tag   = "R1 idle line";
        for (int g = 0; g < 5; g++) begin
            inj_pattern(6'h27);
            inj_pattern(6'h27);
            inj_ones(1);
        end
        for (int g = 0; g < 3; g++) inj_pattern(6'h27);
        chk(rx_empty == 1'b1, "R7 seven of ten rejected", int'(rx_empty), 1);
        exp_rx.push_back(6'h27);
        inj_pattern(6'h27);
        inj_ones(11);
        chk(exp_rx.size() == 0, "R7 eight of ten accepted", exp_rx.size(), 0);
        chk(exp_tx.size() == 0, "R2 all tx bits seen", exp_tx.size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule